// File: doc/BRIEF.md
# Three-Cell Overcharge Supervisor with Bleed Control

This block watches three series cells for overcharge. External comparators give, for each cell, a flag that is high while the cell sits at or above the trip level, and a flag that is high while the cell sits at or below the release level (trip minus the hysteresis). The trip flags come in without a clock relation and pass through a two-flop synchronizer. An overcharge counts only when some trip flag stays high for a programmable number of clock ticks. Once it counts, the block asserts a charge-disable output and turns on a bleed enable for each cell that went over the trip level, so that those high cells are pulled down.

The delay limit is sampled from `dly_cfg` in the first clock after reset is released and is held from then on. A discharge-start flag cancels a latched overcharge at once. A monitor-active flag keeps all bleed enables low. A low level on the remote-on input forces both the charge-disable and the discharge-disable outputs high.

The controller has three states. `ST_IDLE` waits for any synchronized trip flag (transition IDLE->QUAL). `ST_QUAL` counts ticks. It returns to IDLE when every trip flag has dropped (abort, QUAL->IDLE) and moves on to latched when the count is at or above the limit while a flag is still high (QUAL->LATCH). `ST_LATCH` drives charge-disable. It goes back to IDLE on discharge start (cancel) or when every cell reports release (release, LATCH->IDLE).

Top module: `ovc_supervisor`

## Requirements
- R1: With the delay limit set to D, a trip flag that goes high and stays high makes `chg_off` rise after exactly D+4 rising clock edges, counted from the first edge after the change. The flag is set between edges. Edges 1 and 2 are the synchronizer, edge 3 enters QUAL, and the edge D+4 latches.
- R2: When every trip flag drops before the latch, the tick count is discarded. A new trip must then run a full delay again, and `chg_off` stays low meanwhile.
- R3: On the latch, `bleed_en[i]` goes high for each cell i whose synchronized trip flag is high and whose release flag is low. Bit i of each per-cell bus belongs to cell i.
- R4: A latched `chg_off` clears only once all three release flags are high. Each `bleed_en[i]` clears on its own one edge after `rel_ok[i]` goes high, and the other cells are not affected.
- R5: While latched, a high `dsg_start` clears `chg_off` and every bleed enable on the next edge.
- R6: After a discharge-start cancel, a new persistent trip latches again after the full delay, even when no release flag has gone high in between.
- R7: While `mon_active` is high, `bleed_en` is all zero, whatever the latched state. The per-cell bleed flags keep their values and show up again when `mon_active` goes low.
- R8: While `remote_on` is low, `chg_off` and `dsg_off` are both high. While `remote_on` is high, `dsg_off` is low.
- R9: The delay limit is taken from `dly_cfg` in the first clock after reset. Later changes to `dly_cfg` do not change the qualification time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dly_cfg | input | CNT_W | Delay limit in ticks, sampled once after reset |
| trip_raw | input | NCELL | Per-cell at-or-above-trip flags, asynchronous |
| rel_ok | input | NCELL | Per-cell at-or-below-release flags |
| dsg_start | input | 1 | Discharge current detected across the charge switch |
| mon_active | input | 1 | Cell monitor mode active, suppresses bleeding |
| remote_on | input | 1 | Pack attached to the host, low forces both switches off |
| chg_off | output | 1 | Charge switch disable |
| dsg_off | output | 1 | Discharge switch disable |
| bleed_en | output | NCELL | Per-cell bleed current enables |

## Verification
The hardest case to reach is the exact latch edge. The synchronizer, the state entry and the counter compare all add cycles, so a check that samples one cycle off would pass for the wrong reason. The stimulus sets a trip flag between edges and checks `chg_off` low after D+3 edges and high after D+4. It repeats this after moving `dly_cfg` without a reset, which shows that the captured limit is the one in use. Re-detection without release is reached by cancelling a latch with `dsg_start` while the release flag of the tripped cell stays low, then raising the trip flag again.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUAL  = 2'd1,
        ST_LATCH = 2'd2
    } ovc_state_e;
endpackage

// File: rtl/ovc_sync.sv
module ovc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;
endmodule

// File: rtl/ovc_qual_timer.sv
module ovc_qual_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] dly_cfg,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] limit_q;
    logic             loaded_q;
    logic [CNT_W-1:0] cnt_q;

    // limit captured once, in the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q  <= '0;
            loaded_q <= 1'b0;
        end else if (!loaded_q) begin
            limit_q  <= dly_cfg;
            loaded_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q >= limit_q);
endmodule

// File: rtl/ovc_bleed_ctl.sv
module ovc_bleed_ctl #(
    parameter int NCELL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latched,
    input  logic             entering,
    input  logic             flush,
    input  logic [NCELL-1:0] trip_s,
    input  logic [NCELL-1:0] rel_ok,
    input  logic             mon_active,
    output logic [NCELL-1:0] bleed_en
);
    logic [NCELL-1:0] hot_q;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hot_q[i] <= 1'b0;
            end else if (flush) begin
                hot_q[i] <= 1'b0;
            end else if (rel_ok[i]) begin
                hot_q[i] <= 1'b0;
            end else if ((entering || latched) && trip_s[i]) begin
                hot_q[i] <= 1'b1;
            end
        end
        assign bleed_en[i] = hot_q[i] && !mon_active;
    end
endmodule

// File: rtl/ovc_supervisor.sv
module ovc_supervisor #(
    parameter int NCELL = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] dly_cfg,
    input  logic [NCELL-1:0] trip_raw,
    input  logic [NCELL-1:0] rel_ok,
    input  logic             dsg_start,
    input  logic             mon_active,
    input  logic             remote_on,
    output logic             chg_off,
    output logic             dsg_off,
    output logic [NCELL-1:0] bleed_en
);
    import ovc_pkg::*;

    ovc_state_e       state_q, state_d;
    logic [NCELL-1:0] trip_sync;
    logic             qual_done;
    logic             any_trip;
    logic             all_rel;
    logic             latched;
    logic             entering;
    logic             flush;

    ovc_sync #(.W(NCELL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (trip_raw),
        .d_out (trip_sync)
    );

    assign any_trip = |trip_sync;
    assign all_rel  = &rel_ok;

    ovc_qual_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .dly_cfg (dly_cfg),
        .run     ((state_q == ST_QUAL) && any_trip),
        .done    (qual_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_trip) state_d = ST_QUAL;
            ST_QUAL: begin
                if (!any_trip)      state_d = ST_IDLE;   // abort
                else if (qual_done) state_d = ST_LATCH;  // latch
            end
            ST_LATCH: begin
                if (dsg_start)      state_d = ST_IDLE;   // cancel
                else if (all_rel)   state_d = ST_IDLE;   // release
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        latched  = (state_q == ST_LATCH);
        entering = (state_q == ST_QUAL) && (state_d == ST_LATCH);
        flush    = latched && (state_d != ST_LATCH);
        chg_off  = latched || !remote_on;
        dsg_off  = !remote_on;
    end

    ovc_bleed_ctl #(.NCELL(NCELL)) u_bleed (
        .clk        (clk),
        .rst_n      (rst_n),
        .latched    (latched),
        .entering   (entering),
        .flush      (flush),
        .trip_s     (trip_sync),
        .rel_ok     (rel_ok),
        .mon_active (mon_active),
        .bleed_en   (bleed_en)
    );
endmodule

// File: rtl/ovc_supervisor_chk.sv
module ovc_supervisor_chk #(
    parameter int NCELL = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCELL-1:0] rel_ok,
    input logic             dsg_start,
    input logic             mon_active,
    input logic             remote_on,
    input logic             chg_off,
    input logic             dsg_off,
    input logic [NCELL-1:0] bleed_en,
    input ovc_pkg::ovc_state_e state_q,
    input logic             qual_done,
    input logic [NCELL-1:0] trip_sync
);
    import ovc_pkg::*;

    AST_NO_EARLY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL && !qual_done) |=> (state_q != ST_LATCH)); // R1

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL && trip_sync == '0) |=> (state_q == ST_IDLE)); // R2

    AST_BLEED_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bleed_en != '0) |-> chg_off); // R3

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && (&rel_ok)) |=> (state_q == ST_IDLE && bleed_en == '0)); // R4

    AST_DSG_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && dsg_start) |=> (bleed_en == '0)); // R5

    AST_MON_NO_BLEED: assert property (@(posedge clk) disable iff (!rst_n)
        mon_active |-> (bleed_en == '0)); // R7

    AST_REMOTE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !remote_on |-> (chg_off && dsg_off)); // R8
endmodule

bind ovc_supervisor ovc_supervisor_chk #(.NCELL(NCELL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_ok     (rel_ok),
    .dsg_start  (dsg_start),
    .mon_active (mon_active),
    .remote_on  (remote_on),
    .chg_off    (chg_off),
    .dsg_off    (dsg_off),
    .bleed_en   (bleed_en),
    .state_q    (state_q),
    .qual_done  (qual_done),
    .trip_sync  (trip_sync)
);

// File: tb/tb_ovc_supervisor.sv
module tb_ovc_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int NCELL = 3;
    localparam int CNT_W = 16;
    localparam int D = 8;

    typedef struct packed {
        logic [2:0] trip;
        logic [2:0] rel;
        logic       dsg;
        logic       mon;
        logic       ron;
        logic [7:0] hold;
        logic       e_chg;
        logic       e_dsg;
        logic [2:0] e_bleed;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{3'b000, 3'b111, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 1'b0, 3'b000}, // idle
        '{3'b001, 3'b110, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 1'b0, 3'b000}, // R2 qualifying
        '{3'b000, 3'b110, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 1'b0, 3'b000}, // R2 aborted
        '{3'b001, 3'b110, 1'b0, 1'b0, 1'b1, 8'd6,  1'b0, 1'b0, 3'b000}, // R2 restart from zero
        '{3'b101, 3'b010, 1'b0, 1'b0, 1'b1, 8'd12, 1'b1, 1'b0, 3'b101}, // R3 latch
        '{3'b000, 3'b011, 1'b0, 1'b0, 1'b1, 8'd4,  1'b1, 1'b0, 3'b100}, // R4 per-cell drop
        '{3'b000, 3'b011, 1'b0, 1'b1, 1'b1, 8'd4,  1'b1, 1'b0, 3'b000}, // R7 monitor
        '{3'b000, 3'b111, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 1'b0, 3'b000}, // R4 all released
        '{3'b010, 3'b101, 1'b0, 1'b0, 1'b1, 8'd14, 1'b1, 1'b0, 3'b010}, // R3 latch cell1
        '{3'b000, 3'b101, 1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0, 3'b000}, // R5 cancel
        '{3'b010, 3'b101, 1'b0, 1'b0, 1'b1, 8'd14, 1'b1, 1'b0, 3'b010}, // R6 re-detect
        '{3'b010, 3'b101, 1'b0, 1'b0, 1'b0, 8'd2,  1'b1, 1'b1, 3'b010}, // R8 remote off
        '{3'b000, 3'b111, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 1'b0, 3'b000}  // R8 remote on
    };
    localparam string TAGS [NV] = '{"R0", "R2", "R2", "R2", "R3", "R4", "R7",
                                    "R4", "R3", "R5", "R6", "R8", "R8"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] dly_cfg = CNT_W'(D);
    logic [NCELL-1:0] trip_raw = '0;
    logic [NCELL-1:0] rel_ok = '1;
    logic             dsg_start = 1'b0;
    logic             mon_active = 1'b0;
    logic             remote_on = 1'b1;
    logic             chg_off;
    logic             dsg_off;
    logic [NCELL-1:0] bleed_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovc_supervisor #(.NCELL(NCELL), .CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dly_cfg    (dly_cfg),
        .trip_raw   (trip_raw),
        .rel_ok     (rel_ok),
        .dsg_start  (dsg_start),
        .mon_active (mon_active),
        .remote_on  (remote_on),
        .chg_off    (chg_off),
        .dsg_off    (dsg_off),
        .bleed_en   (bleed_en)
    );

    task automatic check(input string tag, input logic e_chg, input logic e_dsg,
                         input logic [2:0] e_bleed);
        n_cmp++;
        if (chg_off !== e_chg || dsg_off !== e_dsg || bleed_en !== e_bleed) begin
            n_bad++;
            $display("FAIL %s: chg=%b dsg=%b bleed=%b expected chg=%b dsg=%b bleed=%b",
                     tag, chg_off, dsg_off, bleed_en, e_chg, e_dsg, e_bleed);
        end
    endtask

    task automatic boundary(input string tag);
        @(negedge clk);
        trip_raw = 3'b100; rel_ok = 3'b011;
        repeat (D + 3) @(posedge clk);
        @(negedge clk);
        check(tag, 1'b0, 1'b0, 3'b000);
        @(posedge clk);
        @(negedge clk);
        check(tag, 1'b1, 1'b0, 3'b100);
        trip_raw = 3'b000; rel_ok = 3'b111;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tag, 1'b0, 1'b0, 3'b000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset state", 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            trip_raw   = TBL[v].trip;
            rel_ok     = TBL[v].rel;
            dsg_start  = TBL[v].dsg;
            mon_active = TBL[v].mon;
            remote_on  = TBL[v].ron;
            repeat (int'(TBL[v].hold)) @(posedge clk);
            @(negedge clk);
            check(TAGS[v], TBL[v].e_chg, TBL[v].e_dsg, TBL[v].e_bleed);
        end

        // R1: exact latch edge with the limit captured at reset
        boundary("R1 latch edge");

        // R9: a new dly_cfg without reset leaves the qualification time alone
        @(negedge clk);
        dly_cfg = CNT_W'(2);
        boundary("R9 limit held");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule